// File: doc/BRIEF.md
# Seekable Register File Port

This block places a small bank of registers behind a host-visible seekable file. The transfer core owns the address counter. It presents the current address and pulses an update strobe for one cycle when the host seeks. The new address is already valid in that strobe cycle. The core then performs writes with a write enable and reads with a read enable, both at the current address. It stalls writes while `wr_full` is high and stalls reads while `rd_empty` is high.

The storage behaves as a slow memory. Fetching a word takes `LATENCY` cycles. After every seek, whatever the address, the block raises `rd_empty` and `wr_full` and holds them until the word at the new address is ready. After every read, the block fetches the word at the next address (wrapping in `ADDR_W` bits) and holds `rd_empty` high until that word is ready. `wr_full` stays low in that case, because it only rises after a seek. Addresses at or above `NUM_REGS` read as zero and ignore writes.

Top module: `seek_regfile_port`

## Requirements
- R1: Out of reset, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R2: A write with `wr_en` high stores `wr_data` at `addr`, and a later seek to that address followed by a read returns it.
- R3: After a cycle with `addr_upd` high, `rd_empty` and `wr_full` are both high for exactly `LATENCY` cycles and then both fall.
- R4: `rd_data` changes only on the clock edge that ends a cycle with `rd_en` high, and it holds that value until the next read.
- R5: After a read at address A, the next read without a seek returns the word at A+1, and `rd_empty` stays high for exactly `LATENCY` cycles in between.
- R6: The automatic next address wraps from 2^`ADDR_W`-1 to 0.
- R7: Addresses at or above `NUM_REGS` read as zero. A write to such an address changes no register, including the register that shares its low-order bits.
- R8: `rd_empty` rises only on the clock after `rd_en` or `addr_upd`. `wr_full` rises only on the clock after `addr_upd` and stays low across read prefetches.
- R9: A write to the address whose word is already fetched and waiting is returned by the next read.
- R10: A second seek during a fetch restarts it. The fetch then targets the newest address and takes the full `LATENCY` from that second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; every port is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Current address from the core |
| addr_upd | input | 1 | One-cycle strobe after a host seek; `addr` holds the new value in the same cycle |
| wr_en | input | 1 | Write cycle at `addr` |
| wr_data | input | DATA_W | Data to write |
| wr_full | output | 1 | Holds off writes while a post-seek fetch is in progress |
| rd_en | input | 1 | Read cycle; data appears on the following clock |
| rd_data | output | DATA_W | Registered read data |
| rd_empty | output | 1 | Holds off reads until the fetched word is ready |

## Verification
A counter that loses its place shows at the ports as a `rd_empty` window longer or shorter than `LATENCY`. The bench measures that window after every seek and every read, so such a fault appears within a few cycles of the first access. A wrong fetch address or a lost write shows as a wrong word on the read that follows. The table pass and the sequential, wrap and bypass cases catch it on the first affected read. A flag that rises without a cause, or `rd_data` that moves outside a read, is flagged in the same cycle.

// File: rtl/srp_pkg.sv
package srp_pkg;
  // Source of the next fetch address
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SEEK = 2'd1,
    SRC_NEXT = 2'd2
  } fetch_src_e;
endpackage

// File: rtl/srp_store.sv
module srp_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rvalid_addr,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rq;
  logic              rin_q;

  // Plain write port and registered read port, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rq    <= mem[ridx];
      rin_q <= rvalid_addr;
    end
  end

  assign rdata = rin_q ? rq : '0;
endmodule

// File: rtl/srp_fetch_timer.sv
module srp_fetch_timer #(
  parameter int unsigned LATENCY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic from_seek,
  output logic done_o,
  output logic busy_o,
  output logic empty_o,
  output logic full_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);
  logic [CNT_W-1:0] cnt;

  assign busy_o = (cnt != '0);
  assign done_o = (cnt == CNT_W'(1)) && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      empty_o <= 1'b1;
      full_o  <= 1'b0;
    end else if (start) begin
      cnt     <= CNT_W'(LATENCY);
      empty_o <= 1'b1;
      if (from_seek) full_o <= 1'b1;
    end else if (busy_o) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        empty_o <= 1'b0;
        full_o  <= 1'b0;
      end
    end
  end

  // R3: completion releases both flags on the next edge
  assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!empty_o && !full_o));
endmodule

// File: rtl/srp_out_stage.sv
module srp_out_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              clear,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] store_word,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              byp_v;
  logic [DATA_W-1:0] byp_d;

  // Newer data written to the waiting address overrides the fetched word
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_v <= 1'b0;
      byp_d <= '0;
    end else if (clear) begin
      byp_v <= 1'b0;
    end else if (wr_hit) begin
      byp_v <= 1'b1;
      byp_d <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data_o <= '0;
    else if (rd_en) rd_data_o <= byp_v ? byp_d : store_word;
  end
endmodule

// File: rtl/seek_regfile_port.sv
module seek_regfile_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned NUM_REGS = 20,
  parameter int unsigned LATENCY  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_upd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  import srp_pkg::*;

  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

  fetch_src_e        src;
  logic [ADDR_W-1:0] fetch_addr;
  logic              start, done, busy;
  logic              wr_ok, fetch_in, wr_hit;
  logic [DATA_W-1:0] store_word;

  assign start    = addr_upd | rd_en;
  assign wr_ok    = wr_en && ({1'b0, addr} < LIMIT);
  assign fetch_in = ({1'b0, fetch_addr} < LIMIT);
  assign wr_hit   = wr_ok && (addr == fetch_addr) && (!busy || done);

  always_comb begin
    if (addr_upd)   src = SRC_SEEK;
    else if (rd_en) src = SRC_NEXT;
    else            src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) fetch_addr <= '0;
    else begin
      case (src)
        SRC_SEEK: fetch_addr <= addr;
        SRC_NEXT: fetch_addr <= addr + 1'b1;
        default:  fetch_addr <= fetch_addr;
      endcase
    end
  end

  srp_fetch_timer #(.LATENCY(LATENCY)) timer_i (
    .clk(clk), .rst(rst), .start(start), .from_seek(addr_upd),
    .done_o(done), .busy_o(busy), .empty_o(rd_empty), .full_o(wr_full)
  );

  srp_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(NUM_REGS)) store_i (
    .clk(clk), .we(wr_ok), .widx(addr[IDX_W-1:0]), .wdata(wr_data),
    .re(done), .rvalid_addr(fetch_in), .ridx(fetch_addr[IDX_W-1:0]),
    .rdata(store_word)
  );

  srp_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .clear(start), .wr_hit(wr_hit),
    .wr_data(wr_data), .store_word(store_word), .rd_data_o(rd_data)
  );

  // Past-value checks start one cycle after reset is released
  logic chk_ok;
  always_ff @(posedge clk) begin
    if (rst) chk_ok <= 1'b0;
    else     chk_ok <= 1'b1;
  end

  assert_empty_cause_R8: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $rose(rd_empty) |-> $past(addr_upd || rd_en));

  assert_full_cause_R8: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $rose(wr_full) |-> $past(addr_upd));

  assert_seek_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    addr_upd |=> (rd_empty && wr_full));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: tb/seek_regfile_port_tb_top.sv
module seek_regfile_port_tb_top;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned NR = 20;
  localparam int unsigned LAT = 3;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [DW-1:0] e;
  } vec_t;

  // Writes in order; expected readback (0 for out-of-range, R7)
  localparam vec_t TBL [8] = '{
    '{6'd0,  32'h1111_0000, 32'h1111_0000},
    '{6'd1,  32'hA5A5_0001, 32'hA5A5_0001},
    '{6'd2,  32'h0BAD_F00D, 32'h0BAD_F00D},
    '{6'd4,  32'h4444_4444, 32'h4444_4444},
    '{6'd19, 32'h1900_0019, 32'h1900_0019},
    '{6'd20, 32'hDEAD_0020, 32'h0000_0000},
    '{6'd36, 32'hCAFE_0036, 32'h0000_0000},
    '{6'd7,  32'h7777_0007, 32'h7777_0007}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          addr_upd = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_full;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_empty;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  seek_regfile_port #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .addr_upd(addr_upd), .wr_en(wr_en),
    .wr_data(wr_data), .wr_full(wr_full), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (wr_full) @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_seek(input logic [AW-1:0] a);
    addr = a; addr_upd = 1'b1;
    @(negedge clk);
    addr_upd = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] got);
    while (rd_empty) @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    got = rd_data;
  endtask

  task automatic measure(output int ne, output int nf);
    ne = 0; nf = 0;
    while (rd_empty) begin
      ne++;
      if (wr_full) nf++;
      @(negedge clk);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    logic [DW-1:0] got, held;
    int ne, nf;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 empty", {31'b0, rd_empty}, 32'd1);
    check("R1 full", {31'b0, wr_full}, 32'd0);
    check("R1 data", rd_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Table pass: write all, then seek and read each (R2, R3, R7)
    for (int i = 0; i < 8; i++) do_write(TBL[i].a, TBL[i].d);
    for (int i = 0; i < 8; i++) begin
      do_seek(TBL[i].a);
      measure(ne, nf);
      check("R3 empty window", ne, LAT);
      check("R3 full window", nf, LAT);
      do_read(TBL[i].a, got);
      check((TBL[i].e == 0) ? "R7 out of range" : "R2 readback", got, TBL[i].e);
    end

    // R5/R8: sequential reads prefetch the next word, full stays low
    do_seek(6'd0);
    measure(ne, nf);
    do_read(6'd0, got);
    check("R5 word0", got, 32'h1111_0000);
    held = got;
    measure(ne, nf);
    check("R5 prefetch window", ne, LAT);
    check("R8 full after read", nf, 0);
    // R4: data held through the prefetch window and idle cycles
    repeat (5) @(negedge clk);
    check("R4 hold", rd_data, held);
    do_read(6'd1, got);
    check("R5 word1", got, 32'hA5A5_0001);
    do_read(6'd2, got);
    check("R5 word2", got, 32'h0BAD_F00D);

    // R6: next address wraps from 63 to 0
    do_seek(6'd63);
    do_read(6'd63, got);
    check("R6 top reads zero", got, 32'd0);
    do_read(6'd0, got);
    check("R6 wrap to 0", got, 32'h1111_0000);

    // R9: write to the waiting address is seen by the next read
    do_seek(6'd7);
    measure(ne, nf);
    do_write(6'd7, 32'h0707_BEEF);
    do_read(6'd7, got);
    check("R9 bypass", got, 32'h0707_BEEF);

    // R10: seek during a fetch restarts it at the newer address
    addr = 6'd1; addr_upd = 1'b1;
    @(negedge clk);
    addr = 6'd2;
    @(negedge clk);
    addr_upd = 1'b0;
    measure(ne, nf);
    check("R10 window", ne, LAT);
    do_read(6'd2, got);
    check("R10 newest addr", got, 32'h0BAD_F00D);

    finished = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule